// File: doc/BRIEF.md
# Frame Extraction Word-Stream Formatter

This block sits between a small frame queue and a host read port. Frames arrive as a stream of 32-bit beats with a byte-enable on the closing beat and two per-frame status flags: abort and prune. The host pulls words one at a time with a read strobe. For each frame, the host first sees a fixed number of header words taken from an input register, then the frame data. Frame boundaries and frame status are carried in the same word stream as reserved 32-bit codes, so the host never reads a separate status register.

The reserved codes are 0x80000000 through 0x80000007. The low three bits select the meaning:
- 0 to 3: end of frame, with the value giving the number of unused bytes in the final data word.
- 4: pruned.
- 5: aborted.
- 6: escape.
- 7: nothing available.

A data word that happens to equal a reserved code is sent behind an escape code, so the host can always tell data from control. A configuration bit reverses the byte order of every word the host reads. A flush input drops whatever frame is queued or in flight. The data-present output tells the host when a read can yield something other than the not-ready code.

Top module: `xtr_word_formatter`

## Requirements
- R1: Every frame begins with HDR_WORDS header words, emitted without escaping. Header word k is `hdr_in[32*k +: 32]`, and word 0 comes first.
- R2: After the header, each buffered data beat is returned in arrival order, unchanged, provided its value lies outside 0x80000000..0x80000007.
- R3: A data word whose value lies in 0x80000000..0x80000007 is returned as 0x80000006 on one read, followed by the literal word on the next read.
- R4: After the last data word of a normal frame, the next read returns 0x80000000 + n. Here n = (4 − v) mod 4, and v is the number of set bits in `in_be` on the last beat. Valid bytes occupy the leading lanes, with lane 3 in bits 31:24 filled first. `in_be` is ignored on other beats.
- R5: When the last beat has `in_prune` set and `in_abort` clear, the frame ends as follows. The read that would have returned that last word returns 0x80000004 instead. The next read returns the literal last word, never escaped. No end-of-frame code follows.
- R6: When the last beat has `in_abort` set, the read that would have returned that last word returns 0x80000005, and this code ends the frame. Abort takes precedence over prune.
- R7: A read when no word is available returns 0x80000007 and changes no state. This applies both when the block is idle and when it is waiting mid-frame for more beats.
- R8: `data_present` is high whenever a buffered beat exists or a frame is partly read out. It is low once the closing code of the last frame has been read, and low after reset.
- R9: With `cfg_swap` high, every returned word, including header and reserved codes, has its four bytes in reverse order.
- R10: While `flush` is high, buffered beats and any partly read frame are discarded, and input beats are accepted and dropped. One cycle after `flush` is high, `data_present` is low. Frames sent afterwards are formatted normally.
- R11: The buffer holds DEPTH beats. `in_ready` is low exactly when the buffer is full and `flush` is low, so no beat is ever lost or overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_data | input | 32 | Input beat data |
| in_be | input | 4 | Byte enables, used on the last beat only |
| in_last | input | 1 | Beat closes the frame |
| in_abort | input | 1 | Frame aborted, sampled on the last beat |
| in_prune | input | 1 | Frame pruned, sampled on the last beat |
| hdr_in | input | 32*HDR_WORDS | Header words for the frame being read out |
| cfg_swap | input | 1 | Reverse byte order of returned words |
| flush | input | 1 | Discard queued and in-flight frame data |
| rd_en | input | 1 | Read strobe; consumes rd_data at the clock edge |
| rd_data | output | 32 | Word returned by a read in this cycle |
| data_present | output | 1 | A frame or part of a frame is pending |

## Verification
Several rules are checked by assertions on every cycle:
- the idle not-ready value, in both byte orders;
- reads on an empty block leaving it empty;
- an escape code always being followed by a reserved-valued literal;
- the cleared state after a flush;
- the full buffer refusing input.

The exact content and order of the word stream cannot be checked that way. This covers the header words, the end-of-frame byte counts, the prune and abort endings, byte swapping across a whole frame, and stalls mid-frame. Only the bench scenarios show these, by comparing every read against a stream predicted from the frames they drive.

// File: rtl/xtr_fmt_pkg.sv
package xtr_fmt_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    // reserved control codes
    localparam logic [WORD_W-1:0] CODE_EOF    = 32'h8000_0000;
    localparam logic [WORD_W-1:0] CODE_PRUNE  = 32'h8000_0004;
    localparam logic [WORD_W-1:0] CODE_ABORT  = 32'h8000_0005;
    localparam logic [WORD_W-1:0] CODE_ESC    = 32'h8000_0006;
    localparam logic [WORD_W-1:0] CODE_NOTRDY = 32'h8000_0007;

    typedef enum logic [1:0] {
        PH_HDR,
        PH_DATA,
        PH_LIT,
        PH_EOF
    } phase_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              last;
        logic [1:0]        eof_n;
        logic              abort;
        logic              prune;
    } beat_t;

    function automatic logic is_reserved(input logic [WORD_W-1:0] w);
        return w[WORD_W-1:3] == CODE_EOF[WORD_W-1:3];
    endfunction

endpackage

// File: rtl/xtr_beat_fifo.sv
module xtr_beat_fifo
    import xtr_fmt_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     push,
    input  beat_t                    push_beat,
    input  logic                     pop,
    output beat_t                    head,
    output logic                     empty,
    output logic                     full,
    output logic [$clog2(DEPTH):0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    beat_t    mem [DEPTH];
    logic     do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH)) && !clr;
        do_pop  = pop && (st_q.cnt != '0) && !clr;
        if (do_push) st_d.wptr = bump(st_q.wptr);
        if (do_pop)  st_d.rptr = bump(st_q.rptr);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wptr] <= push_beat;
    end

    assign head  = mem[st_q.rptr];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign count = st_q.cnt;

endmodule

// File: rtl/xtr_lane_swap.sv
module xtr_lane_swap
    import xtr_fmt_pkg::*;
(
    input  logic              swap,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    logic [WORD_W-1:0] rev;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rev[8*g +: 8] = din[8*(LANES-1-g) +: 8];
    end

    assign dout = swap ? rev : din;

endmodule

// File: rtl/xtr_seq.sv
module xtr_seq
    import xtr_fmt_pkg::*;
#(
    parameter int HDR_WORDS = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        rd_en,
    input  logic                        empty,
    input  beat_t                       head,
    input  logic [WORD_W*HDR_WORDS-1:0] hdr_in,
    output logic                        pop,
    output logic [WORD_W-1:0]           seq_word,
    output logic                        busy
);
    localparam int IW = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;
    localparam logic [IW-1:0] HDR_LAST = IW'(HDR_WORDS - 1);

    typedef struct packed {
        phase_e        phase;
        logic [IW-1:0] hdr_idx;
        logic [1:0]    eof_n;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        pop      = 1'b0;
        seq_word = CODE_NOTRDY;
        case (st_q.phase)
            PH_HDR: begin
                if (!empty) begin
                    seq_word = hdr_in[WORD_W*st_q.hdr_idx +: WORD_W];
                    if (rd_en) begin
                        if (st_q.hdr_idx == HDR_LAST) begin
                            st_d.hdr_idx = '0;
                            st_d.phase   = PH_DATA;
                        end else begin
                            st_d.hdr_idx = st_q.hdr_idx + IW'(1);
                        end
                    end
                end
            end
            PH_DATA: begin
                if (!empty) begin
                    if (head.last && head.abort) begin
                        seq_word = CODE_ABORT;
                        if (rd_en) begin
                            pop        = 1'b1;
                            st_d.phase = PH_HDR;
                        end
                    end else if (head.last && head.prune) begin
                        seq_word = CODE_PRUNE;
                        if (rd_en) st_d.phase = PH_LIT;
                    end else if (is_reserved(head.data)) begin
                        seq_word = CODE_ESC;
                        if (rd_en) st_d.phase = PH_LIT;
                    end else begin
                        seq_word = head.data;
                        if (rd_en) begin
                            pop = 1'b1;
                            if (head.last) begin
                                st_d.phase = PH_EOF;
                                st_d.eof_n = head.eof_n;
                            end
                        end
                    end
                end
            end
            PH_LIT: begin
                if (!empty) begin
                    seq_word = head.data;
                    if (rd_en) begin
                        pop = 1'b1;
                        if (!head.last) begin
                            st_d.phase = PH_DATA;
                        end else if (head.prune) begin
                            st_d.phase = PH_HDR;
                        end else begin
                            st_d.phase = PH_EOF;
                            st_d.eof_n = head.eof_n;
                        end
                    end
                end
            end
            PH_EOF: begin
                seq_word = CODE_EOF | {30'd0, st_q.eof_n};
                if (rd_en) st_d.phase = PH_HDR;
            end
            default: st_d.phase = PH_HDR;
        endcase
        if (clr) begin
            st_d = '{phase: PH_HDR, hdr_idx: '0, eof_n: '0};
            pop  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{phase: PH_HDR, hdr_idx: '0, eof_n: '0};
        else        st_q <= st_d;
    end

    assign busy = (st_q.phase != PH_HDR) || (st_q.hdr_idx != '0);

endmodule

// File: rtl/xtr_word_formatter.sv
module xtr_word_formatter
    import xtr_fmt_pkg::*;
#(
    parameter int HDR_WORDS = 9,
    parameter int DEPTH     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [31:0]            in_data,
    input  logic [3:0]             in_be,
    input  logic                   in_last,
    input  logic                   in_abort,
    input  logic                   in_prune,
    input  logic [32*HDR_WORDS-1:0] hdr_in,
    input  logic                   cfg_swap,
    input  logic                   flush,
    input  logic                   rd_en,
    output logic [31:0]            rd_data,
    output logic                   data_present
);
    localparam int CW = $clog2(DEPTH) + 1;

    beat_t          in_beat, head;
    logic           fifo_empty, fifo_full, fifo_push, fifo_pop;
    logic [CW-1:0]  fifo_count;
    logic [2:0]     be_cnt;
    logic [31:0]    seq_word;
    logic           seq_busy;

    always_comb begin
        be_cnt = '0;
        for (int i = 0; i < LANES; i++) be_cnt = be_cnt + {2'b00, in_be[i]};
    end

    assign in_beat = '{data:  in_data,
                       last:  in_last,
                       eof_n: 2'(3'd4 - be_cnt),
                       abort: in_abort,
                       prune: in_prune};

    assign in_ready  = !fifo_full || flush;
    assign fifo_push = in_valid && !fifo_full && !flush;

    xtr_beat_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (flush),
        .push      (fifo_push),
        .push_beat (in_beat),
        .pop       (fifo_pop),
        .head      (head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .count     (fifo_count)
    );

    xtr_seq #(.HDR_WORDS(HDR_WORDS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (flush),
        .rd_en    (rd_en && !flush),
        .empty    (fifo_empty),
        .head     (head),
        .hdr_in   (hdr_in),
        .pop      (fifo_pop),
        .seq_word (seq_word),
        .busy     (seq_busy)
    );

    xtr_lane_swap u_swap (
        .swap (cfg_swap),
        .din  (seq_word),
        .dout (rd_data)
    );

    assign data_present = seq_busy || !fifo_empty;

endmodule

// File: rtl/xtr_word_formatter_chk.sv
module xtr_word_formatter_chk #(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_ready,
    input  logic                   cfg_swap,
    input  logic                   flush,
    input  logic                   rd_en,
    input  logic [31:0]            rd_data,
    input  logic                   data_present,
    input  logic [$clog2(DEPTH):0] fifo_count
);
    localparam int CW = $clog2(DEPTH) + 1;

    // R7: idle reads yield the not-ready code in the selected byte order
    a_r7_notready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !data_present |-> rd_data == (cfg_swap ? 32'h0700_0080 : 32'h8000_0007));

    // R7: a read on an empty block leaves it empty
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_present && rd_en && !in_valid) |=> !data_present);

    // R3: an escape code is followed by a reserved-valued literal
    a_r3_escape_literal: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !flush && !cfg_swap && rd_data == 32'h8000_0006)
        |=> (cfg_swap || rd_data[31:3] == 29'h1000_0000));

    // R10: flush empties the block
    a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !data_present);

    // R11: occupancy never exceeds the depth
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    // R11: a full buffer refuses input
    a_r11_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == CW'(DEPTH) && !flush) |-> !in_ready);

endmodule

bind xtr_word_formatter xtr_word_formatter_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .cfg_swap     (cfg_swap),
    .flush        (flush),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .data_present (data_present),
    .fifo_count   (fifo_count)
);

// File: tb/sim_xtr_word_formatter.sv
module sim_xtr_word_formatter;
    localparam int HW    = 9;
    localparam int DEPTH = 16;
    localparam logic [31:0] NRDY = 32'h8000_0007;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, in_abort = 1'b0, in_prune = 1'b0;
    logic [31:0] in_data = '0;
    logic [3:0]  in_be = '0;
    logic cfg_swap = 1'b0, flush = 1'b0;
    logic mon_rd = 1'b0, dir_rd = 1'b0, mon_en = 1'b1;
    logic in_ready, data_present, rd_en;
    logic [31:0] rd_data;
    logic [32*HW-1:0] hdr_in;

    int checks = 0, errors = 0;
    logic [31:0] exp_q[$];
    logic [31:0] frm[$];

    always #5 clk = ~clk;
    assign rd_en = mon_rd | dir_rd;

    for (genvar k = 0; k < HW; k++) begin : g_hdr
        assign hdr_in[32*k +: 32] = 32'hA500_0000 + k;
    end

    xtr_word_formatter #(.HDR_WORDS(HW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_be(in_be), .in_last(in_last),
        .in_abort(in_abort), .in_prune(in_prune), .hdr_in(hdr_in),
        .cfg_swap(cfg_swap), .flush(flush), .rd_en(rd_en),
        .rd_data(rd_data), .data_present(data_present));

    function automatic logic [31:0] sw(input logic [31:0] w);
        return cfg_swap ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: reads one word per cycle while something is expected
    initial begin
        forever begin
            @(negedge clk);
            mon_rd = 1'b0;
            if (mon_en && data_present && exp_q.size() > 0) begin
                if (!(rd_data == sw(NRDY) && exp_q[0] != sw(NRDY))) begin
                    check(rd_data == exp_q[0], "R1 R2 R3 R4 R5 R6 R9 stream word",
                          rd_data, exp_q[0]);
                    void'(exp_q.pop_front());
                    mon_rd = 1'b1;
                end
            end
        end
    end

    // driver: predicts the stream from the requirements, then drives the beats
    task automatic send_frame(input int nb, input bit ab, input bit pr, input int gap_at);
        int n = frm.size();
        for (int k = 0; k < HW; k++) exp_q.push_back(sw(32'hA500_0000 + k));   // R1
        for (int i = 0; i < n; i++) begin
            logic [31:0] w = frm[i];
            bit last = (i == n - 1);
            if (last && ab) exp_q.push_back(sw(32'h8000_0005));                // R6
            else if (last && pr) begin                                         // R5
                exp_q.push_back(sw(32'h8000_0004));
                exp_q.push_back(sw(w));
            end else begin
                if (w[31:3] == 29'h1000_0000) exp_q.push_back(sw(32'h8000_0006)); // R3
                exp_q.push_back(sw(w));                                        // R2
                if (last) exp_q.push_back(sw(32'h8000_0000 | ((4 - nb) & 3))); // R4
            end
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = frm[i];
            in_last  = (i == n - 1);
            in_be    = (nb == 4) ? 4'hF : (nb == 3) ? 4'hE : (nb == 2) ? 4'hC : 4'h8;
            in_abort = ab;
            in_prune = pr;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            if (i == gap_at) begin
                @(negedge clk);
                in_valid = 1'b0;
                repeat (40) @(negedge clk);
                // R7 R8: stalled mid-frame, reads return not-ready yet data pending
                check(rd_data == sw(NRDY) && data_present, "R7 R8 mid-frame stall",
                      rd_data, sw(NRDY));
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        while (exp_q.size() > 0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2 stream complete", 32'(exp_q.size()), 0);
        check(!data_present, "R8 low after frame end", {31'd0, data_present}, 0);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=done", cyc);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state: R7 R8 R11
        check(!data_present, "R8 reset", {31'd0, data_present}, 0);
        check(in_ready, "R11 reset ready", {31'd0, in_ready}, 1);
        check(rd_data == NRDY, "R7 idle code", rd_data, NRDY);
        // R7: idle read changes nothing
        dir_rd = 1'b1;
        @(negedge clk);
        dir_rd = 1'b0;
        check(rd_data == NRDY && !data_present, "R7 idle read no change", rd_data, NRDY);

        // R1 R2 R4: plain frames with each final byte count
        frm = '{32'h0102_0304, 32'h1111_2222, 32'h7FFF_FFFF, 32'h8000_0008, 32'hDEAD_BEEF};
        send_frame(4, 0, 0, -1); drain();
        frm = '{32'h0A0B_0C0D, 32'h5555_AAAA};
        send_frame(3, 0, 0, -1); drain();
        send_frame(2, 0, 0, -1); drain();
        send_frame(1, 0, 0, -1); drain();

        // R3: reserved-valued data, including the last word
        frm = '{32'h8000_0000, 32'h1234_5678, 32'h8000_0007, 32'h8000_0006, 32'h8000_0005};
        send_frame(4, 0, 0, -1); drain();

        // R5: pruned frame whose last word is reserved-valued, never escaped
        frm = '{32'h2222_3333, 32'h8000_0004, 32'h8000_0003};
        send_frame(4, 0, 1, -1); drain();

        // R6: aborted frame, and abort together with prune
        frm = '{32'h4444_5555, 32'h6666_7777, 32'h8888_9999};
        send_frame(2, 1, 0, -1); drain();
        send_frame(2, 1, 1, -1); drain();

        // R7 R8: stall after the second beat
        frm = '{32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 32'h0000_0004};
        send_frame(4, 0, 0, 1); drain();

        // R9: byte swap on header, data and codes
        cfg_swap = 1'b1;
        @(negedge clk);
        check(rd_data == 32'h0700_0080, "R9 swapped idle code", rd_data, 32'h0700_0080);
        frm = '{32'h0102_0304, 32'h8000_0002, 32'hAABB_CCDD};
        send_frame(3, 0, 0, -1); drain();
        cfg_swap = 1'b0;

        // R11: backpressure with a frame longer than the buffer
        mon_en = 1'b0;
        frm.delete();
        for (int i = 0; i < DEPTH + 3; i++) frm.push_back(32'h0100_0000 + i);
        fork
            send_frame(4, 0, 0, -1);
        join_none
        repeat (DEPTH + 10) @(negedge clk);
        check(!in_ready, "R11 full buffer stalls input", {31'd0, in_ready}, 0);
        mon_en = 1'b1;
        wait fork;
        drain();

        // R10: flush drops a queued frame, then normal operation resumes
        mon_en = 1'b0;
        frm = '{32'h9999_0000, 32'h9999_0001, 32'h9999_0002};
        send_frame(4, 0, 0, -1);
        @(negedge clk);
        check(data_present, "R8 pending before flush", {31'd0, data_present}, 1);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        check(!data_present, "R10 flush clears", {31'd0, data_present}, 0);
        check(rd_data == NRDY, "R10 not-ready after flush", rd_data, NRDY);
        exp_q.delete();
        mon_en = 1'b1;
        frm = '{32'h3141_5926, 32'h2718_2818};
        send_frame(4, 0, 0, -1); drain();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule